// File: doc/BRIEF.md
# Audio Pause Qualifier

This block turns a raw per-cycle "audio below threshold" indication from an analog level comparator into a debounced pause flag. The flag is active low. The comparator itself, its filtering and any station-search logic that reacts to the flag sit outside the block. Time is measured in ticks of a coarse timing strobe, nominally 1 ms, that the clock generator supplies. The block counts ticks and ignores raw clock cycles.

A pause is declared only after the input has stayed quiet for a programmable number of ticks. That number comes from a two-bit pause-time code, which is doubled when the oscillator-select bit is set. Once a pause is declared, the audio must stay continuously loud for a fixed number of ticks before the pause ends. A brief burst of audio therefore cannot break a pause.

The two threshold-step bits are carried straight through to the analog comparator. The pause flag is a level output, so a downstream tuner controller can start an alternative-frequency search when it goes low.

Top module: `pause_qual`

## Requirements
- R1: While reset is asserted and right after it is released, `pauseN` is high (no pause) and both qualification counters are cleared.
- R2: While idle with `quietIn` high every cycle, `pauseN` falls at the clock edge that samples the Nth `tickIn` pulse. N = (pauseTime+1) × ASSERT_UNIT when `oscSel` is 0, and twice that when `oscSel` is 1. After N−1 such ticks, `pauseN` is still high.
- R3: While idle, a single cycle with `quietIn` low clears the quiet count, so a further full N ticks of quiet are needed before `pauseN` falls.
- R4: While paused with `quietIn` low every cycle, `pauseN` rises at the edge that samples the RELEASE_TICKS-th tick. After RELEASE_TICKS−1 ticks it is still low.
- R5: While paused, a single cycle with `quietIn` high clears the release count, so a further full RELEASE_TICKS ticks of audio are needed before `pauseN` rises.
- R6: Any change of `{oscSel, pauseTime}` restarts the count in progress. The count then runs against the new N. The change alone never moves `pauseN`.
- R7: `levelOut` equals `levelSel` at all times, for all four codes.
- R8: Clock cycles without a `tickIn` pulse never advance either count. `pauseN` changes only at an edge that samples `tickIn` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickIn | input | 1 | One-cycle timing strobe, one per time unit |
| quietIn | input | 1 | Comparator output, 1 = audio below threshold |
| oscSel | input | 1 | Oscillator-select bit; 1 doubles the pause qualification time |
| pauseTime | input | 2 | Pause-time code 0..3 |
| levelSel | input | 2 | Threshold step code for the comparator |
| levelOut | output | 2 | Threshold step code driven to the comparator |
| pauseN | output | 1 | Pause flag, low while a pause is declared |

## Verification
The bench builds the block with ASSERT_UNIT = 3 and RELEASE_TICKS = 3. The longest quiet window is then 24 ticks, so all eight combinations of `oscSel` and `pauseTime` can be swept in a single run. For each combination the bench checks both sides of the assert boundary, both sides of the release boundary, and a one-cycle interruption in each direction. A configuration change part-way through a count shows that the count restarts against the new target, and that `pauseN` holds while paused.

// File: rtl/pause_qual_pkg.sv
package pause_qual_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_PAUSED = 1'b1
  } pauseState_e;

  // Strobes from the control to the counting datapath
  typedef struct packed {
    logic clrAssert;
    logic incAssert;
    logic clrRel;
    logic incRel;
  } ctlStrobe_t;

endpackage

// File: rtl/pause_qual_dp.sv
module pause_qual_dp
  import pause_qual_pkg::*;
#(
  parameter int ASSERT_UNIT   = 8,
  parameter int RELEASE_TICKS = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic       oscSel,
  input  logic [1:0] pauseTime,
  output logic       assertLast,
  output logic       relLast
);

  localparam int CNT_W = $clog2(ASSERT_UNIT * 8 + 1);
  localparam int REL_W = $clog2(RELEASE_TICKS + 1);

  logic [CNT_W-1:0] assertCnt;
  logic [REL_W-1:0] relCnt;
  logic [CNT_W-1:0] baseTicks;
  logic [CNT_W-1:0] targetTicks;

  // Quiet target: (code + 1) units, doubled by the oscillator-select bit
  always_comb begin
    baseTicks   = CNT_W'({1'b0, pauseTime} + 3'd1) * CNT_W'(ASSERT_UNIT);
    targetTicks = oscSel ? {baseTicks[CNT_W-2:0], 1'b0} : baseTicks;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      assertCnt <= '0;
    end else if (strobe.clrAssert) begin
      assertCnt <= '0;
    end else if (strobe.incAssert) begin
      assertCnt <= assertCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relCnt <= '0;
    end else if (strobe.clrRel) begin
      relCnt <= '0;
    end else if (strobe.incRel) begin
      relCnt <= relCnt + REL_W'(1);
    end
  end

  assign assertLast = (assertCnt >= (targetTicks - CNT_W'(1)));
  assign relLast    = (relCnt >= REL_W'(RELEASE_TICKS - 1));

endmodule

// File: rtl/pause_qual_ctl.sv
module pause_qual_ctl
  import pause_qual_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       quietIn,
  input  logic [2:0] cfgIn,
  input  logic       assertLast,
  input  logic       relLast,
  output ctlStrobe_t strobe,
  output logic       paused
);

  pauseState_e state, stateNext;
  logic [2:0]  cfgQ;
  logic        cfgChg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else begin
      cfgQ <= cfgIn;
    end
  end

  assign cfgChg = (cfgIn != cfgQ);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.clrRel = 1'b1;
        if (cfgChg || !quietIn) begin
          strobe.clrAssert = 1'b1;
        end else if (tickIn) begin
          if (assertLast) begin
            strobe.clrAssert = 1'b1;
            stateNext        = ST_PAUSED;
          end else begin
            strobe.incAssert = 1'b1;
          end
        end
      end
      ST_PAUSED: begin
        strobe.clrAssert = 1'b1;
        if (cfgChg || quietIn) begin
          strobe.clrRel = 1'b1;
        end else if (tickIn) begin
          if (relLast) begin
            strobe.clrRel = 1'b1;
            stateNext     = ST_IDLE;
          end else begin
            strobe.incRel = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  assign paused = (state == ST_PAUSED);

endmodule

// File: rtl/pause_qual.sv
module pause_qual
  import pause_qual_pkg::*;
#(
  parameter int ASSERT_UNIT   = 8,
  parameter int RELEASE_TICKS = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       quietIn,
  input  logic       oscSel,
  input  logic [1:0] pauseTime,
  input  logic [1:0] levelSel,
  output logic [1:0] levelOut,
  output logic       pauseN
);

  ctlStrobe_t strobe;
  logic       assertLast;
  logic       relLast;
  logic       paused;

  pause_qual_ctl ctlInst (
    .clk        (clk),
    .rstN       (rstN),
    .tickIn     (tickIn),
    .quietIn    (quietIn),
    .cfgIn      ({oscSel, pauseTime}),
    .assertLast (assertLast),
    .relLast    (relLast),
    .strobe     (strobe),
    .paused     (paused)
  );

  pause_qual_dp #(
    .ASSERT_UNIT   (ASSERT_UNIT),
    .RELEASE_TICKS (RELEASE_TICKS)
  ) dpInst (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .oscSel     (oscSel),
    .pauseTime  (pauseTime),
    .assertLast (assertLast),
    .relLast    (relLast)
  );

  assign levelOut = levelSel;
  assign pauseN   = ~paused;

endmodule

// File: rtl/pause_qual_chk.sv
module pause_qual_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tickIn,
  input logic       quietIn,
  input logic       oscSel,
  input logic [1:0] pauseTime,
  input logic       pauseN
);

  always @(negedge clk) begin
    if (!rstN) begin
      // R1
      reset_idle_chk: assert (pauseN);
    end
  end

  // R8
  pause_edge_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pauseN) |-> $past(tickIn));

  // R3
  loud_keeps_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pauseN && !quietIn) |=> pauseN);

  // R5
  quiet_keeps_pause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pauseN && quietIn) |=> !pauseN);

  // R6
  cfg_no_glitch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({oscSel, pauseTime}) |=> $stable(pauseN));

endmodule

bind pause_qual pause_qual_chk chkInst (.*);

// File: tb/pause_qual_test.sv
module pause_qual_test;

  localparam int CLK_PERIOD = 10;
  localparam int UNIT       = 3;
  localparam int REL        = 3;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tickIn;
  logic       quietIn;
  logic       oscSel;
  logic [1:0] pauseTime;
  logic [1:0] levelSel;
  logic [1:0] levelOut;
  logic       pauseN;

  int nChecks = 0;
  int nFails  = 0;

  pause_qual #(.ASSERT_UNIT(UNIT), .RELEASE_TICKS(REL)) uut (
    .clk       (clk),
    .rstN      (rstN),
    .tickIn    (tickIn),
    .quietIn   (quietIn),
    .oscSel    (oscSel),
    .pauseTime (pauseTime),
    .levelSel  (levelSel),
    .levelOut  (levelOut),
    .pauseN    (pauseN)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tickIn = 1'b1;
      @(negedge clk) tickIn = 1'b0;
    end
  endtask

  task automatic blip(input logic v);
    @(negedge clk) quietIn = v;
    @(negedge clk) quietIn = ~v;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN      = 1'b0;
    tickIn    = 1'b0;
    quietIn   = 1'b1;
    oscSel    = 1'b0;
    pauseTime = 2'd0;
    levelSel  = 2'd0;
    repeat (3) @(negedge clk);
    check("R1 pauseN in reset", int'(pauseN), 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 pauseN after reset", int'(pauseN), 1);

    // R7: every threshold code passes through
    for (int l = 0; l < 4; l++) begin
      levelSel = 2'(l);
      #1;
      check("R7 levelOut", int'(levelOut), l);
    end

    quietIn = 1'b0;
    for (int c = 0; c < 8; c++) begin
      int target;
      oscSel    = c[2];
      pauseTime = c[1:0];
      target    = (c % 4 + 1) * UNIT * (c[2] ? 2 : 1);
      repeat (2) @(negedge clk);
      quietIn = 1'b1;
      // R8: quiet cycles without ticks never qualify
      repeat (target + 2) @(negedge clk);
      check("R8 no tick no pause", int'(pauseN), 1);
      pulse(target - 1);
      check("R2 one tick short", int'(pauseN), 1);
      blip(1'b0);
      pulse(target - 1);
      check("R3 loud cycle restarts count", int'(pauseN), 1);
      pulse(1);
      check("R2 pause at target", int'(pauseN), 0);
      quietIn = 1'b0;
      pulse(REL - 1);
      check("R4 release one tick short", int'(pauseN), 0);
      blip(1'b1);
      pulse(REL - 1);
      check("R5 quiet cycle restarts release", int'(pauseN), 0);
      pulse(1);
      check("R4 release at fixed time", int'(pauseN), 1);
    end

    // R6: change of configuration mid-count restarts against new target
    oscSel    = 1'b0;
    pauseTime = 2'd0;
    repeat (2) @(negedge clk);
    quietIn = 1'b1;
    pulse(UNIT - 1);
    pauseTime = 2'd1;
    pulse(1);
    check("R6 old target not honoured", int'(pauseN), 1);
    pulse(2 * UNIT - 2);
    check("R6 new target one short", int'(pauseN), 1);
    pulse(1);
    check("R6 new target reached", int'(pauseN), 0);
    @(negedge clk) pauseTime = 2'd3;
    @(negedge clk) oscSel = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 pause held across change", int'(pauseN), 0);
    quietIn = 1'b0;
    pulse(REL - 1);
    @(negedge clk) oscSel = 1'b0;
    pulse(1);
    check("R6 release restarted by change", int'(pauseN), 0);
    pulse(REL - 1);
    check("R6 release after restart", int'(pauseN), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule